// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block turns single read and write requests from a simple request port into command slots for one 16-bit SDRAM device. After reset it runs a fixed bring-up: close all banks, refresh, then load the mode register with a constant word. It then keeps one row open. A request to the open row goes straight to a column command. A request to another row first closes all banks and then opens the new row. When no row is open, the row is opened first.

A refresh interval counter raises a refresh request at a programmable spacing. That request takes priority over new requests. The sequencer closes any open row and then issues the refresh. The SDRAM clock is derived from the core clock by a selectable ratio. Every command, including the idle no-operation state, stays on the pins for exactly one SDRAM clock period.

The byte enables go all-active on every read and stay that way until a write loads its own mask. Address bit 10 has a separate pin, so the all-bank close can raise it without touching the 14-bit address bus.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset is released, the first three commands are, in order, close-all-banks, refresh and mode-register load. After that, no command is issued until a request or a refresh needs one.
- R2: Commands are encoded on {row strobe, column strobe, write enable}, all active low: activate 011, read 101, write 100, close-all-banks 010, refresh 001, mode-register load 000. Idle is 111.
- R3: A mode-register load drives 0x0030 on the 14-bit address bus, with the A10 pin low.
- R4: A close-all-banks command drives the A10 pin high.
- R5: An activate drives the request row on the address bus and row bit 10 on the A10 pin. A read or write drives the zero-extended column on the address bus, with the A10 pin low.
- R6: A request to the open row issues only its column command. A request when no row is open issues activate, then the column command. A request to a different row issues close-all-banks, activate, then the column command. Each of these takes consecutive SDRAM clocks.
- R7: Requests to the open row that are presented back to back are issued as column commands on consecutive SDRAM clocks.
- R8: Both active-low byte enables reset to 11. A read drives them to 00. A write loads the request's active-low mask. No other command changes them.
- R9: Clock ratio select codes 0, 1, 2 and 3 give SDRAM clocks of 1, 2, 4 and 8 core cycles. Every command, and the idle state, is held for the whole SDRAM clock.
- R10: With a non-zero interval N, a refresh is requested every N SDRAM clocks. Before the next request is served, it is carried out as close-all-banks (only if a row is open) followed by refresh. An interval of 0 stops refresh.
- R11: Chip select is low exactly during slots that carry a command. During idle slots it is high and all three strobes are high.
- R12: The request-ready output is high only in the core cycle whose clock edge issues that request's column command, so each accepted request produces exactly one column command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| clk_div_sel_i | input | 2 | SDRAM clock ratio code, held steady outside reset |
| refresh_interval_i | input | 16 | Refresh spacing in SDRAM clocks, 0 turns refresh off |
| req_valid_i | input | 1 | Request present |
| req_write_i | input | 1 | 1 for write, 0 for read |
| req_row_i | input | 14 | Row address of the request |
| req_col_i | input | 8 | Column address of the request |
| req_be_ni | input | 2 | Active-low byte mask used by writes |
| req_ready_o | output | 1 | Request accepted at this clock edge |
| sd_cs_n_o | output | 1 | Chip select, active low |
| sd_ras_n_o | output | 1 | Row strobe, active low |
| sd_cas_n_o | output | 1 | Column strobe, active low |
| sd_we_n_o | output | 1 | Write enable, active low |
| sd_be_n_o | output | 2 | Byte enables, active low |
| sd_addr_o | output | 14 | Address bus |
| sd_a10_o | output | 1 | Dedicated address bit 10 |

## Verification
The bench goes after the row policy. A hit, a miss and a closed-row request must produce one, three and two commands. A sequencer that skips the close on a miss would activate over an open row, and one that re-activates on every hit would pad the command count.

It watches the byte enables across the close and activate that follow a read. A design that drops the all-active state on a non-write command would show 11 there.

It measures the spacing of refreshes and the slot length at each clock ratio. An off-by-one counter or a command held for a single core cycle shows up directly in the logged command counts.

It also presents two hits back to back. A ready signal that is registered, instead of being tied to the issuing edge, would issue the first request twice or leave a gap between the two column commands.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

   // {row strobe, column strobe, write enable}, active low
   typedef enum logic [2:0] {
      CMD_MRS   = 3'b000,
      CMD_REFR  = 3'b001,
      CMD_DCAB  = 3'b010,
      CMD_ACTV  = 3'b011,
      CMD_WRITE = 3'b100,
      CMD_READ  = 3'b101,
      CMD_NOP   = 3'b111
   } sd_cmd_e;

   localparam logic [13:0] MODE_WORD = 14'h0030;

endpackage

// File: rtl/sdram_tick_gen.sv
module sdram_tick_gen #(
   parameter int SEL_W = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [SEL_W-1:0] ratio_i,
   output logic             tick_o
);
   // largest divisor is 2**(2**SEL_W - 1); count up to divisor-1
   localparam int CNT_W = (1 << SEL_W) - 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] one;
   logic [CNT_W-1:0] reload;

   assign one    = {{(CNT_W-1){1'b0}}, 1'b1};
   assign reload = (one << ratio_i) - one;
   assign tick_o = (cnt_q == '0);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         cnt_q <= '0;
      else if (tick_o)     cnt_q <= reload;
      else                 cnt_q <= cnt_q - one;
   end

   initial begin
      assert (SEL_W >= 1 && SEL_W <= 3) else $error("SEL_W out of range");
   end

   // slots longer than one core cycle never tick twice in a row
   assert_slot_gap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_o && ratio_i != '0) |=> !tick_o);

endmodule

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
   parameter int REF_W = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic [REF_W-1:0] interval_i,
   input  logic             clear_i,
   output logic             pending_o
);
   logic [REF_W-1:0] cnt_q;
   logic             armed;
   logic             hit;

   assign armed = (interval_i != '0);
   assign hit   = tick_i && armed && (cnt_q >= interval_i - 1'b1);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q     <= '0;
         pending_o <= 1'b0;
      end else begin
         if (tick_i && armed) begin
            if (hit) cnt_q <= '0;
            else     cnt_q <= cnt_q + 1'b1;
         end
         pending_o <= hit | (pending_o & ~clear_i);
      end
   end

   initial begin
      assert (REF_W >= 2) else $error("REF_W too small");
   end

   // a zero interval never raises a new refresh request
   assert_refresh_off_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (interval_i == '0 && !pending_o) |=> !pending_o);

endmodule

// File: rtl/sdram_cmd_fsm.sv
module sdram_cmd_fsm
   import sdram_seq_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int COL_W  = 8,
   parameter int BE_W   = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              ref_pend_i,
   output logic              ref_clear_o,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_row_i,
   input  logic [COL_W-1:0]  req_col_i,
   input  logic [BE_W-1:0]   req_be_ni,
   output logic              req_ready_o,
   output sd_cmd_e           cmd_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic              a10_o,
   output logic [BE_W-1:0]   be_no
);
   localparam int A10_BIT = 10;
   localparam logic [1:0] STEP_DCAB = 2'd0;
   localparam logic [1:0] STEP_REFR = 2'd1;
   localparam logic [1:0] STEP_MRS  = 2'd2;
   localparam logic [1:0] STEP_DONE = 2'd3;

   logic [1:0]        step_q, step_d;
   logic              open_q, open_d;
   logic [ADDR_W-1:0] row_q, row_d;
   sd_cmd_e           cmd_q, cmd_d;
   logic [ADDR_W-1:0] addr_q, addr_d;
   logic              a10_q, a10_d;
   logic [BE_W-1:0]   be_q, be_d;
   logic              accept_c, clear_c;
   logic [ADDR_W-1:0] col_ext;
   logic              row_hit;

   generate
      if (COL_W < ADDR_W) begin : g_col_pad
         assign col_ext = {{(ADDR_W-COL_W){1'b0}}, req_col_i};
      end else begin : g_col_full
         assign col_ext = req_col_i;
      end
   endgenerate

   assign row_hit = open_q && (row_q == req_row_i);

   always_comb begin
      step_d   = step_q;
      open_d   = open_q;
      row_d    = row_q;
      cmd_d    = CMD_NOP;
      addr_d   = addr_q;
      a10_d    = a10_q;
      be_d     = be_q;
      accept_c = 1'b0;
      clear_c  = 1'b0;
      if (step_q != STEP_DONE) begin
         unique case (step_q)
            STEP_DCAB: begin
               cmd_d  = CMD_DCAB;
               addr_d = '0;
               a10_d  = 1'b1;
               step_d = STEP_REFR;
            end
            STEP_REFR: begin
               cmd_d  = CMD_REFR;
               step_d = STEP_MRS;
            end
            default: begin
               cmd_d  = CMD_MRS;
               addr_d = MODE_WORD[ADDR_W-1:0];
               a10_d  = 1'b0;
               step_d = STEP_DONE;
            end
         endcase
      end else if (ref_pend_i) begin
         if (open_q) begin
            cmd_d  = CMD_DCAB;
            addr_d = '0;
            a10_d  = 1'b1;
            open_d = 1'b0;
         end else begin
            cmd_d   = CMD_REFR;
            clear_c = 1'b1;
         end
      end else if (req_valid_i) begin
         if (!open_q) begin
            cmd_d  = CMD_ACTV;
            addr_d = req_row_i;
            a10_d  = req_row_i[A10_BIT];
            open_d = 1'b1;
            row_d  = req_row_i;
         end else if (!row_hit) begin
            cmd_d  = CMD_DCAB;
            addr_d = '0;
            a10_d  = 1'b1;
            open_d = 1'b0;
         end else begin
            cmd_d    = req_write_i ? CMD_WRITE : CMD_READ;
            addr_d   = col_ext;
            a10_d    = 1'b0;
            be_d     = req_write_i ? req_be_ni : '0;
            accept_c = 1'b1;
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         step_q <= STEP_DCAB;
         open_q <= 1'b0;
         row_q  <= '0;
         cmd_q  <= CMD_NOP;
         addr_q <= '0;
         a10_q  <= 1'b0;
         be_q   <= '1;
      end else if (tick_i) begin
         step_q <= step_d;
         open_q <= open_d;
         row_q  <= row_d;
         cmd_q  <= cmd_d;
         addr_q <= addr_d;
         a10_q  <= a10_d;
         be_q   <= be_d;
      end
   end

   assign req_ready_o = accept_c & tick_i;
   assign ref_clear_o = clear_c & tick_i;
   assign cmd_o       = cmd_q;
   assign addr_o      = addr_q;
   assign a10_o       = a10_q;
   assign be_no       = be_q;

   initial begin
      assert (ADDR_W > A10_BIT) else $error("address bus must reach bit 10");
      assert (COL_W <= A10_BIT) else $error("column must stay below bit 10");
   end

   assert_mode_word_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_q == CMD_MRS) |-> (addr_q == MODE_WORD[ADDR_W-1:0] && !a10_q));

   assert_close_a10_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_q == CMD_DCAB) |-> a10_q);

   assert_column_open_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_q == CMD_READ || cmd_q == CMD_WRITE) |-> open_q);

   assert_read_be_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_q == CMD_READ) |-> (be_q == '0));

   assert_slot_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable({cmd_q, addr_q, a10_q, be_q}));

   assert_ready_column_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_ready_o |=> (cmd_q == CMD_READ || cmd_q == CMD_WRITE));

endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
   import sdram_seq_pkg::*;
#(
   parameter int ADDR_W = 14,
   parameter int COL_W  = 8,
   parameter int BE_W   = 2,
   parameter int SEL_W  = 2,
   parameter int REF_W  = 16
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [SEL_W-1:0]  clk_div_sel_i,
   input  logic [REF_W-1:0]  refresh_interval_i,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic [ADDR_W-1:0] req_row_i,
   input  logic [COL_W-1:0]  req_col_i,
   input  logic [BE_W-1:0]   req_be_ni,
   output logic              req_ready_o,
   output logic              sd_cs_n_o,
   output logic              sd_ras_n_o,
   output logic              sd_cas_n_o,
   output logic              sd_we_n_o,
   output logic [BE_W-1:0]   sd_be_n_o,
   output logic [ADDR_W-1:0] sd_addr_o,
   output logic              sd_a10_o
);
   logic    tick;
   logic    ref_pend;
   logic    ref_clear;
   sd_cmd_e cmd;

   sdram_tick_gen #(.SEL_W(SEL_W)) u_tick (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .ratio_i (clk_div_sel_i),
      .tick_o  (tick)
   );

   sdram_refresh_timer #(.REF_W(REF_W)) u_refresh (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (tick),
      .interval_i (refresh_interval_i),
      .clear_i    (ref_clear),
      .pending_o  (ref_pend)
   );

   sdram_cmd_fsm #(.ADDR_W(ADDR_W), .COL_W(COL_W), .BE_W(BE_W)) u_fsm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .ref_pend_i  (ref_pend),
      .ref_clear_o (ref_clear),
      .req_valid_i (req_valid_i),
      .req_write_i (req_write_i),
      .req_row_i   (req_row_i),
      .req_col_i   (req_col_i),
      .req_be_ni   (req_be_ni),
      .req_ready_o (req_ready_o),
      .cmd_o       (cmd),
      .addr_o      (sd_addr_o),
      .a10_o       (sd_a10_o),
      .be_no       (sd_be_n_o)
   );

   assign {sd_ras_n_o, sd_cas_n_o, sd_we_n_o} = cmd;
   assign sd_cs_n_o = (cmd == CMD_NOP);

   // idle slots deselect the device with every strobe high
   assert_idle_deselect_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sd_cs_n_o |-> (sd_ras_n_o && sd_cas_n_o && sd_we_n_o));

endmodule

// File: tb/sdram_cmd_seq_tb.sv
`timescale 1ns/1ps
module sdram_cmd_seq_tb;
   localparam logic [2:0] E_MRS = 3'b000, E_REFR = 3'b001, E_DCAB = 3'b010,
                          E_ACTV = 3'b011, E_WR = 3'b100, E_RD = 3'b101;
   // {write, row[13:0], col[7:0], be_n[1:0], commands expected[1:0]}
   localparam int NV = 8;
   localparam logic [26:0] VEC [NV] = '{
      {1'b1, 14'h0123, 8'h05, 2'b10, 2'd2},
      {1'b0, 14'h0123, 8'h06, 2'b11, 2'd1},
      {1'b1, 14'h0123, 8'h07, 2'b01, 2'd1},
      {1'b0, 14'h2456, 8'h40, 2'b11, 2'd3},
      {1'b0, 14'h2456, 8'hFF, 2'b11, 2'd1},
      {1'b1, 14'h3FFF, 8'h00, 2'b00, 2'd3},
      {1'b1, 14'h0000, 8'h80, 2'b11, 2'd3},
      {1'b0, 14'h0000, 8'h01, 2'b11, 2'd1}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] div_sel = 2'd0;
   logic [15:0] interval = 16'd0;
   logic req_valid = 1'b0, req_write = 1'b0;
   logic [13:0] req_row = '0;
   logic [7:0] req_col = '0;
   logic [1:0] req_be = 2'b11;
   logic ready, cs_n, ras_n, cas_n, we_n, a10;
   logic [1:0] be_n;
   logic [13:0] addr;

   int n_chk = 0, n_fail = 0, cyc = 0, log_n = 0;
   bit done = 0;
   logic [2:0]  lg_cmd [256];
   logic [13:0] lg_addr[256];
   logic        lg_a10 [256];
   logic [1:0]  lg_be  [256];
   int          lg_cyc [256];

   always #2 clk = ~clk;

   sdram_cmd_seq u_dut (
      .clk_i(clk), .rst_ni(rst_n), .clk_div_sel_i(div_sel),
      .refresh_interval_i(interval), .req_valid_i(req_valid),
      .req_write_i(req_write), .req_row_i(req_row), .req_col_i(req_col),
      .req_be_ni(req_be), .req_ready_o(ready), .sd_cs_n_o(cs_n),
      .sd_ras_n_o(ras_n), .sd_cas_n_o(cas_n), .sd_we_n_o(we_n),
      .sd_be_n_o(be_n), .sd_addr_o(addr), .sd_a10_o(a10)
   );

   always @(negedge clk) begin
      cyc++;
      if (rst_n && !cs_n && log_n < 256) begin
         lg_cmd[log_n]  = {ras_n, cas_n, we_n};
         lg_addr[log_n] = addr;
         lg_a10[log_n]  = a10;
         lg_be[log_n]   = be_n;
         lg_cyc[log_n]  = cyc;
         log_n++;
      end
   end

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic issue(logic wr, logic [13:0] row, logic [7:0] col, logic [1:0] be);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_row = row; req_col = col; req_be = be;
      #1;
      while (!ready) begin @(negedge clk); #1; end
      @(posedge clk); #1;
      req_valid = 1'b0;
   endtask

   task automatic reset_with(logic [1:0] sel);
      @(negedge clk);
      rst_n = 1'b0; div_sel = sel; interval = '0;
      repeat (3) @(negedge clk);
      log_n = 0;
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++; n_chk++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic        open_m;
      logic [13:0] row_m;
      logic [1:0]  be_m;
      int start, r;
      open_m = 0; row_m = '0; be_m = 2'b11;

      // reset state (R8, R11)
      repeat (4) @(negedge clk);
      #1;
      chk("R11 reset cs_n", cs_n, 1);
      chk("R11 reset strobes", {ras_n, cas_n, we_n}, 3'b111);
      chk("R8 reset be_n", be_n, 2'b11);
      log_n = 0;
      rst_n = 1'b1;
      repeat (10) @(negedge clk);
      #1;
      // bring-up (R1, R2, R3, R4)
      chk("R1 bring-up count", log_n, 3);
      chk("R1 first close", lg_cmd[0], E_DCAB);
      chk("R4 close a10", lg_a10[0], 1);
      chk("R1 refresh second", lg_cmd[1], E_REFR);
      chk("R2 mode load code", lg_cmd[2], E_MRS);
      chk("R3 mode word", lg_addr[2], 14'h0030);
      chk("R3 mode a10", lg_a10[2], 0);
      chk("R1 consecutive slots", lg_cyc[2] - lg_cyc[0], 2);

      // vector walk (R2, R5, R6, R8)
      for (int v = 0; v < NV; v++) begin
         logic wr; logic [13:0] row; logic [7:0] col; logic [1:0] be; int n, k;
         {wr, row, col, be, n} = {VEC[v][26], VEC[v][25:12], VEC[v][11:4], VEC[v][3:2], 32'(VEC[v][1:0])};
         start = log_n;
         issue(wr, row, col, be);
         @(negedge clk); #1;
         chk("R6 command count", log_n - start, n);
         k = start;
         if (open_m && row_m != row) begin
            chk("R6 miss close", lg_cmd[k], E_DCAB);
            chk("R4 miss close a10", lg_a10[k], 1);
            chk("R8 be held on close", lg_be[k], be_m);
            k++;
            open_m = 0;
         end
         if (!open_m) begin
            chk("R6 activate", lg_cmd[k], E_ACTV);
            chk("R5 activate row", lg_addr[k], row);
            chk("R5 activate a10", lg_a10[k], row[10]);
            chk("R8 be held on activate", lg_be[k], be_m);
            k++;
            open_m = 1; row_m = row;
         end
         be_m = wr ? be : 2'b00;
         chk("R2 column code", lg_cmd[k], wr ? E_WR : E_RD);
         chk("R5 column addr", lg_addr[k], {6'd0, col});
         chk("R5 column a10", lg_a10[k], 0);
         chk("R8 column be", lg_be[k], be_m);
         if (k > start) chk("R6 consecutive", lg_cyc[k] - lg_cyc[start], k - start);
      end

      // back-to-back hits (R7, R12)
      start = log_n;
      @(negedge clk);
      req_valid = 1; req_write = 0; req_row = 14'h0000; req_col = 8'h10; #1;
      chk("R12 hit ready", ready, 1);
      @(posedge clk); #1;
      req_col = 8'h11; #1;
      chk("R7 second ready", ready, 1);
      @(posedge clk); #1;
      req_valid = 0; #1;
      chk("R12 no ready when idle", ready, 0);
      @(negedge clk); #1;
      chk("R7 two columns", log_n - start, 2);
      chk("R7 first col", lg_addr[start], 14'h0010);
      chk("R7 second col", lg_addr[start+1], 14'h0011);
      chk("R7 consecutive", lg_cyc[start+1] - lg_cyc[start], 1);

      // refresh (R10)
      @(negedge clk);
      start = log_n;
      interval = 16'd20;
      repeat (70) @(negedge clk);
      #1;
      chk("R10 refresh entries", log_n - start, 4);
      chk("R10 close before refresh", lg_cmd[start], E_DCAB);
      chk("R10 refresh after close", lg_cmd[start+1], E_REFR);
      chk("R10 refresh repeat", lg_cmd[start+3], E_REFR);
      chk("R10 refresh spacing", lg_cyc[start+3] - lg_cyc[start+2], 20);
      interval = 16'd0;
      start = log_n;
      repeat (50) @(negedge clk);
      #1;
      chk("R10 zero interval quiet", log_n - start, 0);
      issue(1'b0, 14'h0000, 8'h02, 2'b11);
      @(negedge clk); #1;
      chk("R10 row reopened", lg_cmd[start], E_ACTV);
      chk("R10 then read", lg_cmd[start+1], E_RD);

      // clock ratios (R9)
      for (int s = 1; s < 4; s++) begin
         r = 1 << s;
         reset_with(2'(s));
         repeat (3 * r + 4) @(negedge clk);
         #1;
         chk("R9 bring-up slots", log_n, 3 * r);
         chk("R9 close held", lg_cmd[r-1], E_DCAB);
         chk("R9 refresh starts", lg_cmd[r], E_REFR);
         chk("R9 mode last", lg_cmd[3*r-1], E_MRS);
         start = log_n;
         issue(1'b1, 14'h0005, 8'h03, 2'b10);
         repeat (r) @(negedge clk);
         #1;
         chk("R9 request slots", log_n - start, 2 * r);
         chk("R9 write held", lg_cmd[start + 2*r - 1], E_WR);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule